// File: doc/BRIEF.md
# Downward-Growing LIFO Stack with Full and Empty Flags

This block keeps a small last-in, first-out store of data words in a register array. A stack pointer starts one place past the highest slot and moves toward slot zero as words are added. A push first lowers the pointer by one and then writes the input word into the slot the pointer now names. A pop first copies the slot the pointer names into the output register and then raises the pointer by one.

Two status outputs report the stack condition, and each is set or cleared only by a pointer move. A push that leaves the pointer at zero raises the full flag and always drops the empty flag. A pop that brings the pointer back to its top value raises the empty flag and always drops the full flag. A request the stack cannot serve has no effect on any state and produces a one-cycle error pulse. Such a request is a push when full, a pop when empty, or a push and a pop in the same cycle.

With the default depth of 11, the valid slots are 0 to 10. Slot 10 is the bottom of the stack and pointer value 11 means empty. A controller issues single-cycle push or pop strobes and reads the popped word from the output register on the cycle after its pop.

Top module: `lifo_stack`

## Requirements
- R1: While reset is asserted and after it is released, isEmpty is 1, isFull is 0, opError is 0 and popData is 0.
- R2: Words are returned in reverse order of storage: each pop delivers the word stored by the most recent push not yet popped.
- R3: One cycle after an accepted pop (popReq=1, pushReq=0, isEmpty=0), popData shows the popped word. popData keeps that value until the next accepted pop, whatever other requests arrive.
- R4: After an accepted push (pushReq=1, popReq=0, isFull=0), isEmpty is 0. isFull is 1 exactly when that push stored the DEPTH-th word (pointer reached 0). isFull and isEmpty are never 1 together.
- R5: After an accepted pop, isFull is 0. isEmpty is 1 exactly when that pop removed the last word (pointer returned to DEPTH).
- R6: A push while isFull=1 changes no stored word, pointer or flag. opError is 1 in the following cycle.
- R7: A pop while isEmpty=1 changes no state and leaves popData unchanged. opError is 1 in the following cycle.
- R8: A push and a pop requested in the same cycle are both ignored, so stack contents, flags and popData stay unchanged. opError is 1 in the following cycle.
- R9: opError is a single-cycle pulse. It is 0 in the cycle after any cycle with no request or with an accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push strobe for one cycle |
| popReq | input | 1 | Pop strobe for one cycle |
| pushData | input | WIDTH | Word to store on a push |
| popData | output | WIDTH | Last word removed by a pop |
| isFull | output | 1 | All DEPTH slots are occupied |
| isEmpty | output | 1 | No slot is occupied |
| opError | output | 1 | One-cycle pulse after a refused request |

## Verification
Push and pop strobes can arrive in the same cycle. The bench drives this case directly, with the stack empty, partly filled and full. It also arises in a long stretch of random strobes, where both are raised together about a quarter of the time. The behavioural model treats such a cycle as a refused request. It expects the error pulse on the next cycle and unchanged flags and popData. A later drain of the stack then shows that no word was written or lost. The same model compares every output after every clock edge, so boundary behaviour is checked each cycle: a simultaneous request on a full or empty stack has to produce exactly one error pulse.

// File: rtl/stack_pkg.sv
package stack_pkg;

  // Strobes from control to datapath; at most one is set in a cycle.
  typedef struct packed {
    logic doPush;
    logic doPop;
  } stackStrobe_t;

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DEPTH = 11,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic          popReq,
  input  logic [PW-1:0] sp,
  output stackStrobe_t  stb,
  output logic          isFull,
  output logic          isEmpty,
  output logic          opError
);

  localparam logic [PW-1:0] LAST_FREE = PW'(1);
  localparam logic [PW-1:0] LAST_USED = PW'(DEPTH - 1);

  logic fullQ, emptyQ, errQ;
  logic pushOk, popOk, refused;

  always_comb begin
    pushOk  = pushReq && !popReq && !fullQ;
    popOk   = popReq && !pushReq && !emptyQ;
    refused = (pushReq || popReq) && !pushOk && !popOk;
    stb.doPush = pushOk;
    stb.doPop  = popOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ  <= 1'b0;
      emptyQ <= 1'b1;
      errQ   <= 1'b0;
    end else begin
      errQ <= refused;
      if (pushOk) begin
        // pointer becomes sp-1; full when it lands on slot 0
        fullQ  <= (sp == LAST_FREE);
        emptyQ <= 1'b0;
      end else if (popOk) begin
        // pointer becomes sp+1; empty when it returns to DEPTH
        emptyQ <= (sp == LAST_USED);
        fullQ  <= 1'b0;
      end
    end
  end

  assign isFull  = fullQ;
  assign isEmpty = emptyQ;
  assign opError = errQ;

endmodule

// File: rtl/stack_dpath.sv
module stack_dpath
  import stack_pkg::*;
#(
  parameter int DEPTH = 11,
  parameter int WIDTH = 16,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackStrobe_t     stb,
  input  logic [WIDTH-1:0] pushData,
  output logic [PW-1:0]    sp,
  output logic [WIDTH-1:0] popData
);

  localparam logic [PW-1:0] SP_EMPTY = PW'(DEPTH);

  logic [PW-1:0]    spQ;
  logic [PW-1:0]    spDec;
  logic [WIDTH-1:0] slot [DEPTH];
  logic [WIDTH-1:0] topWord;
  logic [WIDTH-1:0] popQ;

  assign spDec = spQ - PW'(1);

  // Pointer: pre-decrement on push, post-increment on pop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           spQ <= SP_EMPTY;
    else if (stb.doPush) spQ <= spDec;
    else if (stb.doPop)  spQ <= spQ + PW'(1);
  end

  // One register per slot, written at the decremented pointer.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                slot[i] <= '0;
      else if (stb.doPush && spDec == PW'(i))   slot[i] <= pushData;
    end
  end

  // Read mux at the current pointer.
  always_comb begin
    topWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (spQ == PW'(i)) topWord = slot[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          popQ <= '0;
    else if (stb.doPop) popQ <= topWord;
  end

  assign sp      = spQ;
  assign popData = popQ;

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import stack_pkg::*;
#(
  parameter int DEPTH = 11,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] popData,
  output logic             isFull,
  output logic             isEmpty,
  output logic             opError
);

  localparam int PW = $clog2(DEPTH + 1);

  stackStrobe_t  stb;
  logic [PW-1:0] sp;

  stack_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .sp(sp), .stb(stb), .isFull(isFull), .isEmpty(isEmpty),
    .opError(opError)
  );

  stack_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .pushData(pushData),
    .sp(sp), .popData(popData)
  );

endmodule

// File: rtl/stack_chk.sv
module stack_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushReq,
  input logic             popReq,
  input logic [WIDTH-1:0] popData,
  input logic             isFull,
  input logic             isEmpty,
  input logic             opError
);

  // R4
  push_clears_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && !isFull) |=> !isEmpty);

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty));

  // R5
  pop_clears_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && !isEmpty) |=> !isFull);

  // R6
  full_push_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && isFull) |=> (opError && isFull && $stable(popData)));

  // R7
  empty_pop_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && isEmpty) |=> (opError && isEmpty && $stable(popData)));

  // R8
  both_req_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> (opError && $stable(popData) && $stable(isFull) && $stable(isEmpty)));

  // R9
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pushReq && !popReq) |=> !opError);

  // R3
  popdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(popReq && !pushReq && !isEmpty) |=> $stable(popData));

endmodule

bind lifo_stack stack_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
  .popData(popData), .isFull(isFull), .isEmpty(isEmpty), .opError(opError)
);

// File: tb/test_lifo_stack.sv
`timescale 1ns/1ps
module test_lifo_stack;

  localparam int DEPTH = 11;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pushReq = 1'b0;
  logic             popReq = 1'b0;
  logic [WIDTH-1:0] pushData = '0;
  logic [WIDTH-1:0] popData;
  logic             isFull, isEmpty, opError;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] expData = '0;
  logic             expErr = 1'b0;

  always #2.5 clk = ~clk;

  lifo_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_lifo_stack (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .pushData(pushData), .popData(popData), .isFull(isFull),
    .isEmpty(isEmpty), .opError(opError)
  );

  task automatic check(input string tag, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, compare all outputs.
  task automatic step(input bit doPush, input bit doPop, input logic [WIDTH-1:0] d);
    string tagF, tagD, tagE;
    bit pushAcc, popAcc;
    @(negedge clk);
    pushReq = doPush; popReq = doPop; pushData = d;
    @(posedge clk);
    pushAcc = doPush && !doPop && (q.size() < DEPTH);
    popAcc  = doPop && !doPush && (q.size() > 0);
    expErr  = (doPush || doPop) && !pushAcc && !popAcc;
    if (pushAcc) q.push_back(d);
    if (popAcc)  expData = q.pop_back();
    tagF = pushAcc ? "R4" : popAcc ? "R5" : (doPush && doPop) ? "R8" : doPush ? "R6" : doPop ? "R7" : "R9";
    tagD = popAcc ? "R2 R3" : (doPush && doPop) ? "R8" : doPop ? "R7" : "R3";
    tagE = (doPush && doPop) ? "R8" : (doPush && !pushAcc) ? "R6" : (doPop && !popAcc) ? "R7" : "R9";
    #1;
    check(tagF, "isFull",  WIDTH'(isFull),  WIDTH'(q.size() == DEPTH));
    check(tagF, "isEmpty", WIDTH'(isEmpty), WIDTH'(q.size() == 0));
    check(tagD, "popData", popData, expData);
    check(tagE, "opError", WIDTH'(opError), WIDTH'(expErr));
  endtask

  initial begin
    // R1: reset state, during and after reset
    #12;
    check("R1", "isEmpty in reset", WIDTH'(isEmpty), WIDTH'(1));
    check("R1", "isFull in reset",  WIDTH'(isFull),  WIDTH'(0));
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", "isEmpty", WIDTH'(isEmpty), WIDTH'(1));
    check("R1", "isFull",  WIDTH'(isFull),  WIDTH'(0));
    check("R1", "opError", WIDTH'(opError), WIDTH'(0));
    check("R1", "popData", popData, WIDTH'(0));

    // R7: pop on empty stack
    step(0, 1, '0);
    step(0, 0, '0);
    // R2: short LIFO run
    step(1, 0, 16'hA001); step(1, 0, 16'hA002); step(1, 0, 16'hA003);
    step(0, 1, '0); step(0, 0, '0); step(0, 1, '0); step(0, 1, '0);
    // R7 after draining, popData must hold
    step(0, 1, '0);
    // R4: fill to full
    for (int i = 0; i < DEPTH; i++) step(1, 0, WIDTH'(16'hB000 + i));
    // R6: push while full, twice
    step(1, 0, 16'hDEAD); step(1, 0, 16'hBEEF); step(0, 0, '0);
    // R8: both at full, then partly filled, then idle R9
    step(1, 1, 16'h1111); step(0, 1, '0); step(1, 1, 16'h2222); step(0, 0, '0);
    // R5 / R2: drain completely
    for (int i = 0; i < DEPTH; i++) step(0, 1, '0);
    // R8 on empty stack
    step(1, 1, 16'h3333); step(0, 0, '0);
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [1:0] r;
      r = 2'($urandom);
      step(r[0], r[1], WIDTH'($urandom));
    end
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, '0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule